// File: doc/BRIEF.md
# LIN Break Generator and Detector

This unit handles the break symbol of a LIN-capable serial port. When software strobes a break request while the port is in LIN mode, the unit pulls the serial output low for a selectable number of bit times. It then drives the line high for one bit time as a delimiter and afterwards returns the line to the normal transmit data. All timing is counted in pulses of an externally supplied bit-time tick.

In the same mode the unit watches the serial input. When the input stays low for a long enough run of bit times, it latches a detection flag. Software can enable an interrupt on that flag and clear the flag with a dedicated strobe. After a detection, the detector stays disarmed until the unit receives a soft reset.

A pin-override path lets software force the output to a fixed level. The raw level of the serial input can always be read back.

Top module: `lin_brk_unit`

## Requirements
- R1: After reset, `ser_out` follows `tx_data`, and `brk_busy`, `brk_seen` and `brk_irq` are all 0.
- R2: A break request (`brk_req`=1 for one cycle) in LIN mode drives `ser_out` low for exactly 13, 14, 15 or 16 bit ticks, for `brk_len_sel` equal to 0, 1, 2 or 3. The code is captured at the moment of the request.
- R3: After the low phase, `ser_out` is high for exactly one bit tick with `brk_busy`=1. After that tick `brk_busy` is 0 and `ser_out` follows `tx_data` again.
- R4: A break request is ignored when `lin_mode`=0. It is also ignored while a break is already being generated, so the low phase is neither restarted nor lengthened.
- R5: In LIN mode, the 11th consecutive bit tick that samples `ser_in` low sets `brk_seen`. The flag is set at the clock edge of that tick. Any cycle with `ser_in` high restarts the count, so a run of 10 low ticks sets nothing.
- R6: `seen_clr`=1 in LIN mode clears `brk_seen`. If a detection happens in the same cycle as a clear, the detection wins and the flag ends up at 1.
- R7: `brk_irq` is 1 exactly when `brk_seen`=1 and `brk_irq_en`=1.
- R8: After a detection, the detector cannot set the flag again, even after a clear, until `unit_clr` is pulsed. `unit_clr` clears the flag, stops any break in progress and re-arms the detector.
- R9: With `pin_ovr_en`=1, `ser_out` equals `pin_ovr_lvl`. `pin_rd` always reflects the current level of `ser_in`.
- R10: With `lin_mode`=0, the detector neither counts nor sets the flag, and `seen_clr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| lin_mode | input | 1 | LIN operating mode selected |
| brk_len_sel | input | 2 | Break length code (0..3 gives 13..16 bits) |
| brk_req | input | 1 | Strobe: start a break |
| seen_clr | input | 1 | Strobe: clear the detection flag |
| brk_irq_en | input | 1 | Interrupt enable for detection |
| unit_clr | input | 1 | Strobe: soft reset of the unit |
| pin_ovr_en | input | 1 | Pin override enable |
| pin_ovr_lvl | input | 1 | Forced output level under override |
| tx_data | input | 1 | Normal serial transmit data |
| ser_in | input | 1 | Serial input line |
| ser_out | output | 1 | Serial output line |
| brk_busy | output | 1 | Break low phase or delimiter in progress |
| brk_seen | output | 1 | Break detected flag |
| brk_irq | output | 1 | Break detection interrupt |
| pin_rd | output | 1 | Read-back of the serial input level |

## Verification
A detection and a software clear of the flag can land in the same clock cycle. The bench provokes this by holding the input low for ten ticks, then raising `seen_clr` in the very cycle that carries the eleventh low tick. The flag must read 1 after that edge, because a new event must not be lost. A second collision is a break request arriving while a break is already running; it is judged by measuring that the low phase keeps its original length.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    localparam int BRK_BASE_LEN = 13;
    localparam int DET_MIN_BITS = 11;

    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_LOW   = 2'd1,
        GEN_DELIM = 2'd2
    } gen_st_e;

    function automatic int unsigned brk_bits(input int base, input logic [1:0] code);
        return int'(base) + int'(code);
    endfunction
endpackage

// File: rtl/lbk_gen.sv
module lbk_gen
    import lbk_pkg::*;
#(
    parameter int BASE_LEN = BRK_BASE_LEN,
    parameter int SEL_W    = 2,
    localparam int LCW     = $clog2(BASE_LEN + (1 << SEL_W))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_clr,
    input  logic             lin_mode,
    input  logic             bit_tick,
    input  logic             req,
    input  logic [SEL_W-1:0] len_sel,
    output logic             drive_low,
    output logic             busy
);
    gen_st_e        st_q;
    logic [LCW-1:0] cnt_q;
    logic [LCW-1:0] last_q;
    logic           last_hit;

    assign last_hit  = (cnt_q == last_q);
    assign drive_low = (st_q == GEN_LOW);
    assign busy      = (st_q != GEN_IDLE);

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            st_q   <= GEN_IDLE;
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            unique case (st_q)
                GEN_IDLE: if (req && lin_mode) begin
                    st_q   <= GEN_LOW;
                    cnt_q  <= '0;
                    last_q <= LCW'(BASE_LEN - 1) + LCW'(len_sel);
                end
                GEN_LOW: if (bit_tick) begin
                    if (last_hit) st_q <= GEN_DELIM;
                    else          cnt_q <= cnt_q + 1'b1;
                end
                GEN_DELIM: if (bit_tick) st_q <= GEN_IDLE;
                default: st_q <= GEN_IDLE;
            endcase
        end
    end

    AST_REQ_IGNORED_NOLIN: assert property (@(posedge clk) disable iff (rst)
        (st_q == GEN_IDLE && !lin_mode) |=> (st_q == GEN_IDLE)) else $error("gen"); // R4
    AST_DELIM_FOLLOWS_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == GEN_LOW && bit_tick && last_hit && !soft_clr) |=> (st_q == GEN_DELIM)) else $error("gen"); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (st_q == GEN_LOW && !bit_tick && !soft_clr) |=> $stable(cnt_q) && $stable(last_q)) else $error("gen"); // R4
endmodule

// File: rtl/lbk_det.sv
module lbk_det
    import lbk_pkg::*;
#(
    parameter int MIN_BITS = DET_MIN_BITS,
    localparam int DCW     = $clog2(MIN_BITS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_clr,
    input  logic lin_mode,
    input  logic bit_tick,
    input  logic line_in,
    input  logic flag_clr,
    output logic flag
);
    logic [DCW-1:0] run_q;
    logic           armed_q;
    logic           hit;

    assign hit = lin_mode && armed_q && bit_tick && !line_in
               && (run_q == DCW'(MIN_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || soft_clr || !lin_mode || line_in) begin
            run_q <= '0;
        end else if (bit_tick && run_q != DCW'(MIN_BITS)) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            armed_q <= 1'b1;
            flag    <= 1'b0;
        end else begin
            if (hit) armed_q <= 1'b0;
            if (hit)                       flag <= 1'b1;
            else if (flag_clr && lin_mode) flag <= 1'b0;
        end
    end

    AST_SET_ON_RUN: assert property (@(posedge clk) disable iff (rst)
        (hit && !soft_clr) |=> flag) else $error("det"); // R5
    AST_STAY_DISARMED: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !soft_clr) |=> !armed_q) else $error("det"); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (flag && flag_clr && lin_mode && !hit) |=> !flag) else $error("det"); // R6
    AST_QUIET_OFF_LIN: assert property (@(posedge clk) disable iff (rst)
        (!lin_mode && !flag) |=> !flag) else $error("det"); // R10
endmodule

// File: rtl/lin_brk_unit.sv
module lin_brk_unit
    import lbk_pkg::*;
#(
    parameter int BASE_LEN = BRK_BASE_LEN,
    parameter int MIN_BITS = DET_MIN_BITS,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             lin_mode,
    input  logic [SEL_W-1:0] brk_len_sel,
    input  logic             brk_req,
    input  logic             seen_clr,
    input  logic             brk_irq_en,
    input  logic             unit_clr,
    input  logic             pin_ovr_en,
    input  logic             pin_ovr_lvl,
    input  logic             tx_data,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             brk_busy,
    output logic             brk_seen,
    output logic             brk_irq,
    output logic             pin_rd
);
    logic gen_low;

    lbk_gen #(.BASE_LEN(BASE_LEN), .SEL_W(SEL_W)) u_gen (
        .clk(clk), .rst(rst), .soft_clr(unit_clr), .lin_mode(lin_mode),
        .bit_tick(bit_tick), .req(brk_req), .len_sel(brk_len_sel),
        .drive_low(gen_low), .busy(brk_busy)
    );

    lbk_det #(.MIN_BITS(MIN_BITS)) u_det (
        .clk(clk), .rst(rst), .soft_clr(unit_clr), .lin_mode(lin_mode),
        .bit_tick(bit_tick), .line_in(ser_in), .flag_clr(seen_clr),
        .flag(brk_seen)
    );

    always_comb begin
        if (pin_ovr_en)    ser_out = pin_ovr_lvl;
        else if (brk_busy) ser_out = !gen_low;
        else               ser_out = tx_data;
    end

    assign brk_irq = brk_seen && brk_irq_en;
    assign pin_rd  = ser_in;

    AST_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (gen_low && !pin_ovr_en) |-> (brk_busy && !ser_out)) else $error("top"); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        brk_irq |-> (brk_seen && brk_irq_en)) else $error("top"); // R7
endmodule

// File: tb/test_lin_brk_unit.sv
module test_lin_brk_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, bit_tick = 0, lin_mode = 1;
    logic [1:0] brk_len_sel = 0;
    logic brk_req = 0, seen_clr = 0, brk_irq_en = 0, unit_clr = 0;
    logic pin_ovr_en = 0, pin_ovr_lvl = 0, tx_data = 1, ser_in = 1;
    logic ser_out, brk_busy, brk_seen, brk_irq, pin_rd;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_brk_unit i_lin_brk_unit (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .lin_mode(lin_mode),
        .brk_len_sel(brk_len_sel), .brk_req(brk_req), .seen_clr(seen_clr),
        .brk_irq_en(brk_irq_en), .unit_clr(unit_clr), .pin_ovr_en(pin_ovr_en),
        .pin_ovr_lvl(pin_ovr_lvl), .tx_data(tx_data), .ser_in(ser_in),
        .ser_out(ser_out), .brk_busy(brk_busy), .brk_seen(brk_seen),
        .brk_irq(brk_irq), .pin_rd(pin_rd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(output logic o, output logic b);
        repeat (3) @(negedge clk);
        bit_tick = 1;
        #1 o = ser_out; b = brk_busy;
        @(negedge clk);
        bit_tick = 0;
    endtask

    task automatic ticks(input int n);
        logic o, b;
        for (int i = 0; i < n; i++) tick(o, b);
    endtask

    task automatic pulse_clr();
        @(negedge clk); unit_clr = 1; @(negedge clk); unit_clr = 0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 ser_out", ser_out, 1);
        chk("R1 busy", brk_busy, 0);
        chk("R1 seen", brk_seen, 0);
        chk("R1 irq", brk_irq, 0);
        tx_data = 0; #1 chk("R1 follows tx", ser_out, 0); tx_data = 1;
    endtask

    task automatic t_gen(input logic [1:0] code, input bit retrig);
        int lows = 0;
        logic o, b;
        bit done = 0;
        brk_len_sel = code;
        @(negedge clk); brk_req = 1; @(negedge clk); brk_req = 0;
        brk_len_sel = ~code;
        for (int i = 0; i < 30 && !done; i++) begin
            if (retrig && i == 5) begin brk_req = 1; @(negedge clk); brk_req = 0; end
            tick(o, b);
            if (!o) lows++;
            else begin
                done = 1;
                chk("R3 delimiter busy", b, 1);
            end
        end
        chk(retrig ? "R4 no restart length" : "R2 low length", lows, 13 + code);
        @(negedge clk);
        chk("R3 idle after delim", brk_busy, 0);
        tx_data = 0; #1 chk("R3 tx resumes", ser_out, 0); tx_data = 1;
    endtask

    task automatic t_gen_nolin();
        lin_mode = 0;
        @(negedge clk); brk_req = 1; @(negedge clk); brk_req = 0;
        #1 chk("R4 ignored outside LIN busy", brk_busy, 0);
        chk("R4 ignored outside LIN out", ser_out, 1);
        lin_mode = 1;
    endtask

    task automatic t_detect();
        pulse_clr();
        brk_irq_en = 1;
        ser_in = 0; ticks(10);
        ser_in = 1; ticks(1);
        chk("R5 ten lows no flag", brk_seen, 0);
        ser_in = 0; ticks(10);
        chk("R5 not before eleventh", brk_seen, 0);
        ticks(1);
        chk("R5 eleventh sets", brk_seen, 1);
        chk("R7 irq set", brk_irq, 1);
        brk_irq_en = 0; #1 chk("R7 irq masked", brk_irq, 0); brk_irq_en = 1;
        ser_in = 1;
        @(negedge clk); seen_clr = 1; @(negedge clk); seen_clr = 0;
        chk("R6 clear", brk_seen, 0);
        chk("R7 irq drops", brk_irq, 0);
        ser_in = 0; ticks(12); ser_in = 1; ticks(1);
        chk("R8 disarmed after detect", brk_seen, 0);
        pulse_clr();
        ser_in = 0; ticks(11); ser_in = 1;
        chk("R8 rearmed by soft reset", brk_seen, 1);
        pulse_clr();
        chk("R8 soft reset clears flag", brk_seen, 0);
    endtask

    task automatic t_collide();
        pulse_clr();
        ser_in = 0; ticks(10);
        repeat (3) @(negedge clk);
        bit_tick = 1; seen_clr = 1;
        @(negedge clk);
        bit_tick = 0; seen_clr = 0;
        chk("R6 set wins over clear", brk_seen, 1);
        ser_in = 1;
    endtask

    task automatic t_nolin_det();
        lin_mode = 0;
        @(negedge clk); seen_clr = 1; @(negedge clk); seen_clr = 0;
        chk("R10 clear ignored outside LIN", brk_seen, 1);
        pulse_clr();
        ser_in = 0; ticks(12); ser_in = 1;
        chk("R10 no detect outside LIN", brk_seen, 0);
        lin_mode = 1;
    endtask

    task automatic t_override();
        pin_ovr_en = 1; pin_ovr_lvl = 0; #1;
        chk("R9 force low", ser_out, 0);
        pin_ovr_lvl = 1; tx_data = 0; #1;
        chk("R9 force high", ser_out, 1);
        ser_in = 0; #1 chk("R9 readback low", pin_rd, 0);
        ser_in = 1; #1 chk("R9 readback high", pin_rd, 1);
        pin_ovr_en = 0; tx_data = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        for (int c = 0; c < 4; c++) t_gen(2'(c), 0);
        t_gen(2'd1, 1);
        t_gen_nolin();
        t_detect();
        t_collide();
        t_nolin_det();
        t_override();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule